// File: doc/BRIEF.md
# Dynamic Bus Sizing Cycle Splitter

This block connects a processor's 32-bit internal request port to an external bus. The external bus can answer any cycle as 32 bits wide or as 16 bits wide. Each internal request carries a dword address, four active-low byte enables, a write flag, a code-fetch flag and write data. The block turns it into one or two external bus cycles. The external side uses three inputs: an active-low size input that is sampled in each data phase, an active-low ready that ends the data phase, and an active-low next-address input that allows the following address to be issued early.

When the bus answers 16 bits wide and both half-words hold active enables, the block runs a second cycle for the upper half-word. For that cycle it moves the upper byte enables down, copies the upper write bytes onto the low lanes, and builds a single 32-bit read result from the two halves. A code prefetch has all four enables active, so under 16-bit sizing it always becomes such a pair. Any waiting data request is held in a one-entry pending register until the second half finishes. Early address pipelining is allowed only on cycles that the bus reports as 32 bits wide.

Top module: `dyn_bus_sizer`

## Requirements
- R1: After reset, `bus_ads` and `rsp_done` are low and `req_ready` is high.
- R2: A request is issued with a one-cycle `bus_ads` pulse. With that pulse, `bus_addr` is the dword address with bits 1:0 at 00, `bus_be_n` equals the request enables, `bus_wr` is 1 for a write and `bus_code` is 1 for a code fetch. The first data phase starts in the cycle after the pulse. When `bus_rdy_n` is sampled low with `bus_size16_n` high, the request completes: `rsp_done` pulses in the next cycle with `rsp_rdata` equal to `bus_rdata`.
- R3: If `bus_size16_n` is low at ready and enables are active in both bits 1:0 and bits 3:2 of `bus_be_n`, a second `bus_ads` follows in the next cycle. With it, `bus_addr` has bit 1 set and `bus_be_n` is {2'b11, request enables 3:2}. During that second cycle, both halves of `bus_wdata` carry write data bits 31:16.
- R4: On such a split, `rsp_done` pulses once, one cycle after the second ready. `rsp_rdata` is then {second `bus_rdata`[15:0], first `bus_rdata`[15:0]}, and no `rsp_done` appears after the first half.
- R5: If only enables 1:0 are active, a 16-bit response completes the request in one cycle and `rsp_rdata` equals `bus_rdata`.
- R6: If only enables 3:2 are active, the request runs a single cycle, and both halves of `bus_wdata` carry write bits 31:16. A 16-bit read then returns {`bus_rdata`[15:0], `bus_rdata`[15:0]}. A 32-bit read returns `bus_rdata`.
- R7: A request accepted while a split code prefetch is in progress gets no `bus_ads` until the prefetch's second half is ready. Its `bus_ads` appears in the same cycle as the prefetch's `rsp_done`.
- R8: After a request is accepted, `req_ready` is low until the pending request is issued.
- R9: In a data phase past its first cycle, the next pending request is issued early when all of these hold: `bus_na_n` is low, `bus_size16_n` is high, `bus_rdy_n` is high, and the current cycle is not a second half. Its `bus_ads` appears in the next cycle. When the current cycle completes, the early request's data phase follows at once with no further `bus_ads`.
- R10: `bus_na_n` has no effect in a data phase where `bus_size16_n` is low: no `bus_ads` follows until that cycle's ready.
- R11: Once an early address has been issued, the current cycle completes as 32 bits wide. It is not split even if `bus_size16_n` is low at its ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Pending register can take a request |
| req_dw_addr | input | AW-2 | Dword address of the request |
| req_be_n | input | 4 | Active-low byte enables, bit n is lane n |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_code | input | 1 | 1 = code fetch |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Merged read data, valid with rsp_done |
| bus_ads | output | 1 | Address strobe, one cycle per bus cycle |
| bus_addr | output | AW | Byte address of the bus cycle |
| bus_be_n | output | 4 | Byte enables of the bus cycle |
| bus_wr | output | 1 | Bus cycle is a write |
| bus_code | output | 1 | Bus cycle is a code fetch |
| bus_wdata | output | 32 | Steered write data for the current data phase |
| bus_rdata | input | 32 | Read data from the bus |
| bus_rdy_n | input | 1 | Active-low end of data phase |
| bus_size16_n | input | 1 | Active-low 16-bit width for this cycle |
| bus_na_n | input | 1 | Active-low permission to issue the next address |

## Verification
Two functions can meet in one clock edge. The first is completion of a split prefetch's second half, which produces a `rsp_done` pulse. The second is issue of the data request that waited behind it, which produces a `bus_ads` pulse with the new address. The bench provokes this by offering a write while the prefetch's first cycle is still in its address phase, then answering both halves as 16 bits wide. It judges the result by sampling that edge and requiring the merged prefetch word and the data request's address together. The early-address path is checked the same way: the pipelined strobe must appear while the previous data phase is still open, and the next-address input must be blocked whenever the size input reports 16 bits.

// File: rtl/dbs_pkg.sv
// Shared widths and request types for the dynamic bus sizer.
// Assumes a fixed 32-bit internal word split into two 16-bit halves.
package dbs_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int LANES  = WORD_W / 8;
    localparam int HLANES = LANES / 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [LANES-1:0]  be_t;

    // Fields of a request other than its address.
    typedef struct packed {
        be_t   be_n;
        logic  wr;
        logic  code;
        word_t wdata;
    } req_body_t;
endpackage

// File: rtl/dbs_pend.sv
// One-entry pending register on the request side.
// It accepts a request when empty and holds it until the sequencer takes it.
// Assumes take is asserted only while out_valid is high.
module dbs_pend
    import dbs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [AW-3:0]   in_addr,
    input  req_body_t       in_body,
    input  logic            take,
    output logic            out_valid,
    output logic [AW-3:0]   out_addr,
    output req_body_t       out_body
);
    // Backpressure whenever the single entry is occupied.
    assign in_ready = !out_valid;

    // Load on handshake, clear when the sequencer takes the entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_body  <= '0;
        end else if (in_valid && in_ready) begin
            out_valid <= 1'b1;
            out_addr  <= in_addr;
            out_body  <= in_body;
        end else if (take) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/dbs_steer.sv
// Write-lane steering and second-half address/enable generation.
// Purely combinational; works on the request in its data phase.
// Assumes the second half always targets byte offset 2 of the dword.
module dbs_steer
    import dbs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-3:0]  cur_addr,
    input  be_t            cur_be_n,
    input  word_t          cur_wdata,
    input  logic           half2,
    output logic [AW-1:0]  hi_addr,
    output be_t            hi_be_n,
    output word_t          wdata_out,
    output logic           low_act,
    output logic           up_act
);
    logic copy_hi;

    // Which halves of the request hold at least one active lane.
    assign low_act = !(&cur_be_n[HLANES-1:0]);
    assign up_act  = !(&cur_be_n[LANES-1:HLANES]);

    // Upper half is steered down on second halves and upper-only requests.
    assign copy_hi = half2 || (!low_act && up_act);

    // Address and enables of the upper-half cycle.
    assign hi_addr = {cur_addr, 2'b10};
    assign hi_be_n = {{HLANES{1'b1}}, cur_be_n[LANES-1:HLANES]};

    // Each half of the bus carries either its own half or the upper half.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign wdata_out[g*HALF_W +: HALF_W] =
            copy_hi ? cur_wdata[HALF_W +: HALF_W] : cur_wdata[g*HALF_W +: HALF_W];
    end
endmodule

// File: rtl/dbs_merge.sv
// Read-data merge for the completing data phase.
// Combinational; the sequencer registers the result with the done pulse.
module dbs_merge
    import dbs_pkg::*;
(
    input  word_t  bus_rdata,
    input  half_t  lo_keep,
    input  logic   half2,
    input  logic   sz16,
    input  logic   low_act,
    input  logic   up_act,
    output word_t  merged
);
    // Select the read word according to the half and width of the cycle.
    always_comb begin
        if (half2)
            merged = {bus_rdata[HALF_W-1:0], lo_keep};
        else if (sz16 && !low_act && up_act)
            merged = {bus_rdata[HALF_W-1:0], bus_rdata[HALF_W-1:0]};
        else
            merged = bus_rdata;
    end
endmodule

// File: rtl/dbs_seq.sv
// Bus-cycle sequencer: launches requests, splits 16-bit cycles, pipelines
// the next address on NA, and returns one done pulse per request.
// Assumes ready is only looked at after the address cycle of a launch.
module dbs_seq
    import dbs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pend_valid,
    input  logic [AW-3:0]   pend_addr,
    input  req_body_t       pend_body,
    output logic            pend_take,
    input  logic [AW-1:0]   hi_addr,
    input  be_t             hi_be_n,
    input  logic            low_act,
    input  logic            up_act,
    input  word_t           merged,
    input  word_t           bus_rdata,
    input  logic            bus_rdy_n,
    input  logic            bus_size16_n,
    input  logic            bus_na_n,
    output logic [AW-3:0]   cur_addr,
    output be_t             cur_be_n,
    output word_t           cur_wdata,
    output logic            half2,
    output logic            sz16,
    output half_t           lo_keep,
    output logic            busy,
    output logic            t1,
    output logic            bus_ads,
    output logic [AW-1:0]   bus_addr,
    output be_t             bus_be_n,
    output logic            bus_wr,
    output logic            bus_code,
    output logic            rsp_done,
    output word_t           rsp_rdata
);
    logic            nxt_valid;
    logic [AW-3:0]   nxt_addr;
    be_t             nxt_be_n;
    word_t           nxt_wdata;
    logic            na_taken;
    logic            ready_hit;
    logic            split;
    logic            finish;
    logic            na_hit;
    logic            load_cur;

    // Effective width of the current cycle: an issued early address forces 32.
    assign sz16 = !bus_size16_n && !na_taken;

    // Data-phase events for this clock.
    assign ready_hit = busy && !t1 && !bus_rdy_n;
    assign split     = ready_hit && sz16 && !half2 && low_act && up_act;
    assign finish    = ready_hit && !split;
    assign na_hit    = busy && !t1 && bus_rdy_n && !bus_na_n && bus_size16_n
                       && !half2 && !nxt_valid && pend_valid;

    // The pending request moves into the data phase directly.
    assign load_cur  = pend_valid && (!busy || (finish && !nxt_valid));
    assign pend_take = load_cur || na_hit;

    // Sequencer state, address-phase outputs and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            t1        <= 1'b0;
            half2     <= 1'b0;
            na_taken  <= 1'b0;
            nxt_valid <= 1'b0;
            nxt_addr  <= '0;
            nxt_be_n  <= '1;
            nxt_wdata <= '0;
            cur_addr  <= '0;
            cur_be_n  <= '1;
            cur_wdata <= '0;
            lo_keep   <= '0;
            bus_ads   <= 1'b0;
            bus_addr  <= '0;
            bus_be_n  <= '1;
            bus_wr    <= 1'b0;
            bus_code  <= 1'b0;
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            bus_ads  <= 1'b0;
            rsp_done <= 1'b0;
            t1       <= 1'b0;
            if (split) begin
                half2    <= 1'b1;
                lo_keep  <= bus_rdata[HALF_W-1:0];
                bus_ads  <= 1'b1;
                t1       <= 1'b1;
                bus_addr <= hi_addr;
                bus_be_n <= hi_be_n;
            end
            if (finish) begin
                rsp_done  <= 1'b1;
                rsp_rdata <= merged;
                half2     <= 1'b0;
                na_taken  <= 1'b0;
                if (nxt_valid) begin
                    nxt_valid <= 1'b0;
                    cur_addr  <= nxt_addr;
                    cur_be_n  <= nxt_be_n;
                    cur_wdata <= nxt_wdata;
                end else if (!pend_valid) begin
                    busy <= 1'b0;
                end
            end
            if (load_cur) begin
                busy      <= 1'b1;
                t1        <= 1'b1;
                cur_addr  <= pend_addr;
                cur_be_n  <= pend_body.be_n;
                cur_wdata <= pend_body.wdata;
            end
            if (na_hit) begin
                nxt_valid <= 1'b1;
                na_taken  <= 1'b1;
                nxt_addr  <= pend_addr;
                nxt_be_n  <= pend_body.be_n;
                nxt_wdata <= pend_body.wdata;
            end
            if (load_cur || na_hit) begin
                bus_ads  <= 1'b1;
                bus_addr <= {pend_addr, 2'b00};
                bus_be_n <= pend_body.be_n;
                bus_wr   <= pend_body.wr;
                bus_code <= pend_body.code;
            end
        end
    end
endmodule

// File: rtl/dyn_bus_sizer.sv
// Top of the dynamic bus sizer: pending register, sequencer, write steering
// and read merge. Assumes the external bus answers each cycle with one ready.
module dyn_bus_sizer
    import dbs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [AW-3:0]  req_dw_addr,
    input  logic [3:0]     req_be_n,
    input  logic           req_wr,
    input  logic           req_code,
    input  logic [31:0]    req_wdata,
    output logic           rsp_done,
    output logic [31:0]    rsp_rdata,
    output logic           bus_ads,
    output logic [AW-1:0]  bus_addr,
    output logic [3:0]     bus_be_n,
    output logic           bus_wr,
    output logic           bus_code,
    output logic [31:0]    bus_wdata,
    input  logic [31:0]    bus_rdata,
    input  logic           bus_rdy_n,
    input  logic           bus_size16_n,
    input  logic           bus_na_n
);
    req_body_t       in_body;
    req_body_t       pend_body;
    logic            pend_valid;
    logic            pend_take;
    logic [AW-3:0]   pend_addr;
    logic [AW-3:0]   cur_addr;
    be_t             cur_be_n;
    word_t           cur_wdata;
    logic            cur_half2;
    logic            seq_sz16;
    half_t           lo_keep;
    logic            seq_busy;
    logic            seq_t1;
    logic [AW-1:0]   hi_addr;
    be_t             hi_be_n;
    logic            low_act;
    logic            up_act;
    word_t           merged;

    // Bundle the request fields for the pending register.
    assign in_body = '{be_n: req_be_n, wr: req_wr, code: req_code, wdata: req_wdata};

    dbs_pend #(.AW(AW)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_addr   (req_dw_addr),
        .in_body   (in_body),
        .take      (pend_take),
        .out_valid (pend_valid),
        .out_addr  (pend_addr),
        .out_body  (pend_body)
    );

    dbs_steer #(.AW(AW)) u_steer (
        .cur_addr  (cur_addr),
        .cur_be_n  (cur_be_n),
        .cur_wdata (cur_wdata),
        .half2     (cur_half2),
        .hi_addr   (hi_addr),
        .hi_be_n   (hi_be_n),
        .wdata_out (bus_wdata),
        .low_act   (low_act),
        .up_act    (up_act)
    );

    dbs_merge u_merge (
        .bus_rdata (bus_rdata),
        .lo_keep   (lo_keep),
        .half2     (cur_half2),
        .sz16      (seq_sz16),
        .low_act   (low_act),
        .up_act    (up_act),
        .merged    (merged)
    );

    dbs_seq #(.AW(AW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .pend_valid   (pend_valid),
        .pend_addr    (pend_addr),
        .pend_body    (pend_body),
        .pend_take    (pend_take),
        .hi_addr      (hi_addr),
        .hi_be_n      (hi_be_n),
        .low_act      (low_act),
        .up_act       (up_act),
        .merged       (merged),
        .bus_rdata    (bus_rdata),
        .bus_rdy_n    (bus_rdy_n),
        .bus_size16_n (bus_size16_n),
        .bus_na_n     (bus_na_n),
        .cur_addr     (cur_addr),
        .cur_be_n     (cur_be_n),
        .cur_wdata    (cur_wdata),
        .half2        (cur_half2),
        .sz16         (seq_sz16),
        .lo_keep      (lo_keep),
        .busy         (seq_busy),
        .t1           (seq_t1),
        .bus_ads      (bus_ads),
        .bus_addr     (bus_addr),
        .bus_be_n     (bus_be_n),
        .bus_wr       (bus_wr),
        .bus_code     (bus_code),
        .rsp_done     (rsp_done),
        .rsp_rdata    (rsp_rdata)
    );
endmodule

// File: rtl/dyn_bus_sizer_chk.sv
// Temporal checks for the dynamic bus sizer, attached by bind.
module dyn_bus_sizer_chk #(
    parameter int AW = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_ready,
    input logic           bus_ads,
    input logic [AW-1:0]  bus_addr,
    input logic [3:0]     bus_be_n,
    input logic           bus_rdy_n,
    input logic           bus_size16_n,
    input logic           rsp_done,
    input logic           seq_busy,
    input logic           seq_t1
);
    // R8
    pend_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    ads_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ads |=> !bus_ads);

    // R2
    done_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(!bus_rdy_n && seq_busy && !seq_t1));

    // R10
    na_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && !seq_t1 && bus_rdy_n && !bus_size16_n) |=> !bus_ads);

    // R3
    second_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ads && bus_addr[1]) |-> (bus_be_n[3:2] == 2'b11));
endmodule

bind dyn_bus_sizer dyn_bus_sizer_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .bus_ads      (bus_ads),
    .bus_addr     (bus_addr),
    .bus_be_n     (bus_be_n),
    .bus_rdy_n    (bus_rdy_n),
    .bus_size16_n (bus_size16_n),
    .rsp_done     (rsp_done),
    .seq_busy     (seq_busy),
    .seq_t1       (seq_t1)
);

// File: tb/tb_dyn_bus_sizer.sv
module tb_dyn_bus_sizer;
    localparam int AW = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic [AW-3:0]  req_dw_addr = '0;
    logic [3:0]     req_be_n = 4'hF;
    logic           req_wr = 1'b0;
    logic           req_code = 1'b0;
    logic [31:0]    req_wdata = '0;
    logic           rsp_done;
    logic [31:0]    rsp_rdata;
    logic           bus_ads;
    logic [AW-1:0]  bus_addr;
    logic [3:0]     bus_be_n;
    logic           bus_wr;
    logic           bus_code;
    logic [31:0]    bus_wdata;
    logic [31:0]    bus_rdata = '0;
    logic           bus_rdy_n = 1'b1;
    logic           bus_size16_n = 1'b1;
    logic           bus_na_n = 1'b1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    dyn_bus_sizer #(.AW(AW)) dut (.*);

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [AW-3:0] a, input logic [3:0] be, input logic wr,
                         input logic code, input logic [31:0] wd);
        req_valid = 1'b1; req_dw_addr = a; req_be_n = be; req_wr = wr;
        req_code = code; req_wdata = wd;
        tick();
        req_valid = 1'b0;
    endtask

    task automatic wait_ads();
        for (int i = 0; i < 8 && !bus_ads; i++) tick();
    endtask

    // One data phase: ready with the given size and read data.
    task automatic ready(input logic sz_n, input logic [31:0] d);
        bus_rdy_n = 1'b0; bus_size16_n = sz_n; bus_rdata = d;
        tick();
        bus_rdy_n = 1'b1; bus_size16_n = 1'b1;
    endtask

    initial begin
        tick(); tick();
        // R1 reset state
        chk(bus_ads == 1'b0, "R1 ads", 32'(bus_ads), 0);
        chk(rsp_done == 1'b0, "R1 done", 32'(rsp_done), 0);
        chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);
        rst_n = 1'b1;
        tick();

        // Sweep over enables, direction and width
        for (int be = 0; be < 15; be++) begin
            for (int wr = 0; wr < 2; wr++) begin
                for (int s = 0; s < 2; s++) begin
                    logic [AW-3:0] a;
                    logic [31:0] wd, d1, d2, ew1, ehi, er;
                    logic lo, up, sz16, spl;
                    a   = 14'(be * 37 + wr * 5 + s * 3 + 1);
                    wd  = 32'hA1B2C3D4 ^ (32'(be) << 20) ^ 32'(wr * 77);
                    d1  = 32'h5E6F7081 + 32'(be * 4099);
                    d2  = 32'h192A3B4C ^ 32'(be * 313);
                    lo  = (be[1:0] != 2'b11);
                    up  = (be[3:2] != 2'b11);
                    sz16 = (s == 0);
                    spl = sz16 && lo && up;
                    ehi = {wd[31:16], wd[31:16]};
                    ew1 = (!lo && up) ? ehi : wd;
                    if (spl) er = {d2[15:0], d1[15:0]};
                    else if (sz16 && !lo && up) er = {d1[15:0], d1[15:0]};
                    else er = d1;

                    issue(a, 4'(be), wr[0], 1'b0, wd);
                    wait_ads();
                    chk(bus_ads && bus_addr == {a, 2'b00}, "R2 addr", 32'(bus_addr), 32'({a, 2'b00}));
                    chk(bus_be_n == 4'(be) && bus_wr == wr[0] && bus_code == 1'b0, "R2 be/wr",
                        {bus_be_n, 3'b0, bus_wr}, {4'(be), 3'b0, wr[0]});
                    tick();
                    // R6 / R3 first-cycle lanes
                    chk(bus_wdata == ew1, "R6 wdata first", bus_wdata, ew1);
                    ready(s[0], d1);
                    if (spl) begin
                        chk(bus_ads && bus_addr == {a, 2'b10}, "R3 second addr", 32'(bus_addr), 32'({a, 2'b10}));
                        chk(bus_be_n == {2'b11, 2'(be >> 2)}, "R3 second be", 32'(bus_be_n), 32'({2'b11, 2'(be >> 2)}));
                        chk(rsp_done == 1'b0, "R4 no early done", 32'(rsp_done), 0);
                        tick();
                        chk(bus_wdata == ehi, "R3 second wdata", bus_wdata, ehi);
                        ready(1'b0, d2);
                    end
                    chk(rsp_done == 1'b1, "R2 R4 R5 done", 32'(rsp_done), 1);
                    chk(rsp_rdata == er, "R4 R5 R6 rdata", rsp_rdata, er);
                    tick();
                    chk(rsp_done == 1'b0 && bus_ads == 1'b0, "R4 R5 single", {rsp_done, bus_ads}, 0);
                end
            end
        end

        // R7 R8: data write waits behind a split prefetch
        issue(14'h0123, 4'h0, 1'b0, 1'b1, 32'h0);
        wait_ads();
        chk(bus_code == 1'b1, "R2 code flag", 32'(bus_code), 1);
        issue(14'h0456, 4'h0, 1'b1, 1'b0, 32'hCAFEF00D);
        chk(req_ready == 1'b0, "R8 backpressure", 32'(req_ready), 0);
        ready(1'b0, 32'h1111AAAA);
        chk(bus_ads && bus_addr == {14'h0123, 2'b10}, "R7 second half first", 32'(bus_addr), 32'({14'h0123, 2'b10}));
        chk(req_ready == 1'b0, "R8 still full", 32'(req_ready), 0);
        tick();
        ready(1'b0, 32'h2222BBBB);
        chk(rsp_done && rsp_rdata == 32'hBBBBAAAA, "R7 prefetch merged", rsp_rdata, 32'hBBBBAAAA);
        chk(bus_ads && bus_addr == {14'h0456, 2'b00} && bus_wr, "R7 data issued", 32'(bus_addr), 32'({14'h0456, 2'b00}));
        chk(req_ready == 1'b1, "R8 ready again", 32'(req_ready), 1);
        tick();
        ready(1'b1, 32'h0);
        chk(rsp_done == 1'b1, "R7 data done", 32'(rsp_done), 1);
        tick();

        // R9: early address on a 32-bit cycle
        issue(14'h0AA0, 4'h0, 1'b0, 1'b0, 32'h0);
        wait_ads();
        issue(14'h0BB0, 4'h0, 1'b0, 1'b0, 32'h0);
        bus_na_n = 1'b0; bus_size16_n = 1'b1;
        tick();
        bus_na_n = 1'b1;
        chk(bus_ads && bus_addr == {14'h0BB0, 2'b00}, "R9 early ads", 32'(bus_addr), 32'({14'h0BB0, 2'b00}));
        chk(rsp_done == 1'b0, "R9 not done yet", 32'(rsp_done), 0);
        ready(1'b1, 32'h0000A0A0);
        chk(rsp_done && rsp_rdata == 32'h0000A0A0 && !bus_ads, "R9 first done", rsp_rdata, 32'h0000A0A0);
        ready(1'b1, 32'h0000B0B0);
        chk(rsp_done && rsp_rdata == 32'h0000B0B0 && !bus_ads, "R9 piped done", rsp_rdata, 32'h0000B0B0);
        tick();

        // R10: next-address ignored on 16-bit cycle
        issue(14'h0CC0, 4'hC, 1'b0, 1'b0, 32'h0);
        wait_ads();
        issue(14'h0DD0, 4'h0, 1'b0, 1'b0, 32'h0);
        bus_na_n = 1'b0; bus_size16_n = 1'b0;
        tick();
        bus_na_n = 1'b1; bus_size16_n = 1'b1;
        chk(bus_ads == 1'b0, "R10 na ignored", 32'(bus_ads), 0);
        tick();
        chk(bus_ads == 1'b0, "R10 still no ads", 32'(bus_ads), 0);
        ready(1'b1, 32'h0000C0C0);
        chk(rsp_done && bus_ads && bus_addr == {14'h0DD0, 2'b00}, "R10 issued at ready", 32'(bus_addr), 32'({14'h0DD0, 2'b00}));
        tick();
        ready(1'b1, 32'h0);
        tick();

        // R11: issued early address forces the current cycle to 32 bits
        issue(14'h0EE0, 4'h0, 1'b0, 1'b0, 32'h0);
        wait_ads();
        issue(14'h0FF0, 4'h0, 1'b0, 1'b0, 32'h0);
        bus_na_n = 1'b0;
        tick();
        bus_na_n = 1'b1;
        ready(1'b0, 32'h12345678);
        chk(rsp_done && rsp_rdata == 32'h12345678, "R11 no split rdata", rsp_rdata, 32'h12345678);
        chk(bus_ads == 1'b0, "R11 no second half", 32'(bus_ads), 0);
        ready(1'b1, 32'h9ABCDEF0);
        chk(rsp_done && rsp_rdata == 32'h9ABCDEF0, "R11 piped done", rsp_rdata, 32'h9ABCDEF0);
        tick();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule